// File: doc/BRIEF.md
# Boot Image Stream Loader

The loader sits behind a message-based serial receiver and turns its byte stream into a boot image written to memory. It pairs bytes into 16-bit words, least significant byte first. It checks a key word, reads a block of reserved words that may carry a new bit-timing value, and captures a 32-bit entry address. It then walks a list of load blocks. Each block has a word count, a 32-bit destination and that many data words. Every data word leaves on a simple write port made of address, data and a one-cycle strobe.

A zero word count ends the image. The loader then pulses done, presents the entry address and stops accepting bytes until the next start pulse. A wrong key stops the loader in the same way and pulses a key error. Input uses a valid/ready handshake, so a byte offered while a data write is still pending stays with the sender until the loader can take it.

Top module: `boot_stream_loader`

## Requirements
- R1: Two accepted bytes form one word: the first byte is bits [7:0] and the second is bits [15:8]; a start pulse discards any unpaired byte.
- R2: The first word must be 0x08AA. Any other value pulses key_err for one cycle, writes no memory and halts the loader until start.
- R3: Eight reserved words follow the key. If the first of them is non-zero, it appears on timing_val and timing_vld goes high. Both hold until the next start.
- R4: timing_val resets to a default of 0x1309: bits [5:0] hold prescaler minus one (10) and bits [15:8] hold time quanta per bit minus one (20). A zero first reserved word leaves this default in place with timing_vld low.
- R5: The next two words are the entry address, high half first. It appears on entry_addr and is stable while done is high.
- R6: Each block is a non-zero word count, then the destination high half and low half, then the data words. Each data word gives one wr_stb pulse with wr_data equal to the word. The first word goes to the destination and each later word to the previous address plus one, carrying across 16-bit boundaries.
- R7: A word count of 0x0000 ends the image and pulses done for exactly one cycle.
- R8: After done or key_err, in_ready stays low until a start pulse. Start returns the loader to key search, restores the default timing and clears timing_vld.
- R9: in_ready is low while a completed data word has not yet produced its write strobe; a byte offered in that window is taken later, never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse: arm for a new image |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Loader can take the byte this cycle |
| wr_stb | output | 1 | Memory write strobe, one cycle per word |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 16 | Memory write data |
| timing_val | output | 16 | Bit-timing value (default or override) |
| timing_vld | output | 1 | An override value was captured |
| entry_addr | output | 32 | Entry address of the image |
| done | output | 1 | One-cycle pulse at the image terminator |
| key_err | output | 1 | One-cycle pulse on a wrong key |

## Verification
The assertions watch properties that hold on every cycle. done and key_err are single-cycle and never occur together. No write follows a key error before start. The loader stays halted after done. An override flag, once set, stays set with a non-zero value, and the entry address is steady while done is high. Only the bench's scenarios can show that bytes pair in the right order, that the write addresses and data match the image (including a destination that crosses a 16-bit boundary), and that a zero first reserved word keeps the default timing. The same applies to stalled bytes arriving intact and to a start pulse in mid-image discarding the partial stream.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
    typedef enum logic [3:0] {
        ST_KEY,
        ST_RSVD,
        ST_EP_HI,
        ST_EP_LO,
        ST_CNT,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_DATA,
        ST_HALT
    } ldr_state_e;
endpackage

// File: rtl/bl_word_pack.sv
module bl_word_pack #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                byte_fire,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic                word_vld,
    output logic [2*BYTE_W-1:0] word
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic              have_lo;
        logic [WORD_W-1:0] word;
        logic              vld;
    } pack_t;

    pack_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (clr) begin
            d = '0;
        end else if (byte_fire) begin
            if (q.have_lo) begin
                d.word    = {byte_in, q.lo};
                d.vld     = 1'b1;
                d.have_lo = 1'b0;
            end else begin
                d.lo      = byte_in;
                d.have_lo = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_vld = q.vld;
    assign word     = q.word;
endmodule

// File: rtl/bl_parser.sv
module bl_parser
    import boot_ldr_pkg::*;
#(
    parameter int          WORD_W         = 16,
    parameter int          RSVD_WORDS     = 8,
    parameter logic [15:0] KEY_WORD       = 16'h08AA,
    parameter logic [15:0] DEFAULT_TIMING = 16'h1309
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  word_vld,
    input  logic [WORD_W-1:0]     word,
    output logic                  wr_req,
    output logic                  load,
    output logic [2*WORD_W-1:0]   load_addr,
    output logic                  halted,
    output logic                  data_phase,
    output logic [WORD_W-1:0]     timing_val,
    output logic                  timing_vld,
    output logic [2*WORD_W-1:0]   entry_addr,
    output logic                  done,
    output logic                  key_err
);
    localparam int ADDR_W = 2 * WORD_W;
    localparam int RCNT_W = (RSVD_WORDS > 1) ? $clog2(RSVD_WORDS) : 1;
    localparam logic [RCNT_W-1:0] RCNT_LAST = RCNT_W'(RSVD_WORDS - 1);

    typedef struct packed {
        ldr_state_e        state;
        logic [RCNT_W-1:0] rcnt;
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] adr_hi;
        logic [ADDR_W-1:0] ep;
        logic [WORD_W-1:0] timing;
        logic              timing_vld;
        logic              done;
        logic              key_err;
    } parse_t;

    parse_t q, d;

    function automatic parse_t fresh();
        parse_t r;
        r        = '0;
        r.state  = ST_KEY;
        r.timing = DEFAULT_TIMING;
        return r;
    endfunction

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.key_err = 1'b0;
        wr_req    = 1'b0;
        load      = 1'b0;
        load_addr = {q.adr_hi, word};
        if (start) begin
            d = fresh();
        end else if (word_vld) begin
            case (q.state)
                ST_KEY: begin
                    if (word == KEY_WORD) begin
                        d.state = ST_RSVD;
                        d.rcnt  = '0;
                    end else begin
                        d.key_err = 1'b1;
                        d.state   = ST_HALT;
                    end
                end
                ST_RSVD: begin
                    if (q.rcnt == '0 && word != '0) begin
                        d.timing     = word;
                        d.timing_vld = 1'b1;
                    end
                    if (q.rcnt == RCNT_LAST) d.state = ST_EP_HI;
                    else                     d.rcnt  = q.rcnt + 1'b1;
                end
                ST_EP_HI: begin
                    d.ep[ADDR_W-1:WORD_W] = word;
                    d.state               = ST_EP_LO;
                end
                ST_EP_LO: begin
                    d.ep[WORD_W-1:0] = word;
                    d.state          = ST_CNT;
                end
                ST_CNT: begin
                    if (word == '0) begin
                        d.done  = 1'b1;
                        d.state = ST_HALT;
                    end else begin
                        d.cnt   = word;
                        d.state = ST_ADR_HI;
                    end
                end
                ST_ADR_HI: begin
                    d.adr_hi = word;
                    d.state  = ST_ADR_LO;
                end
                ST_ADR_LO: begin
                    load    = 1'b1;
                    d.state = ST_DATA;
                end
                ST_DATA: begin
                    wr_req = 1'b1;
                    d.cnt  = q.cnt - 1'b1;
                    if (q.cnt == WORD_W'(1)) d.state = ST_CNT;
                end
                default: d.state = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= fresh();
        else        q <= d;
    end

    assign halted     = (q.state == ST_HALT);
    assign data_phase = (q.state == ST_DATA);
    assign timing_val = q.timing;
    assign timing_vld = q.timing_vld;
    assign entry_addr = q.ep;
    assign done       = q.done;
    assign key_err    = q.key_err;
endmodule

// File: rtl/bl_write_port.sv
module bl_write_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] next_addr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              stb;
    } wport_t;

    wport_t q, d;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (load) begin
            d.next_addr = load_addr;
        end else if (wr_req) begin
            d.stb       = 1'b1;
            d.addr      = q.next_addr;
            d.data      = wr_in;
            d.next_addr = q.next_addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_stb  = q.stb;
    assign wr_addr = q.addr;
    assign wr_data = q.data;
endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader #(
    parameter int BYTE_W     = 8,
    parameter int RSVD_WORDS = 8,
    parameter int PRESCALE   = 10,
    parameter int TQ_PER_BIT = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  in_valid,
    input  logic [BYTE_W-1:0]     in_data,
    output logic                  in_ready,
    output logic                  wr_stb,
    output logic [4*BYTE_W-1:0]   wr_addr,
    output logic [2*BYTE_W-1:0]   wr_data,
    output logic [2*BYTE_W-1:0]   timing_val,
    output logic                  timing_vld,
    output logic [4*BYTE_W-1:0]   entry_addr,
    output logic                  done,
    output logic                  key_err
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = 2 * WORD_W;
    localparam logic [15:0] DEF_TIMING =
        {8'(TQ_PER_BIT - 1), 2'b00, 6'(PRESCALE - 1)};

    logic              byte_fire;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              wr_req;
    logic              load;
    logic [ADDR_W-1:0] load_addr;
    logic              halted;
    logic              data_phase;

    assign in_ready  = !halted && !(word_vld && data_phase);
    assign byte_fire = in_valid && in_ready;

    bl_word_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .byte_fire (byte_fire),
        .byte_in   (in_data),
        .word_vld  (word_vld),
        .word      (word)
    );

    bl_parser #(
        .WORD_W         (WORD_W),
        .RSVD_WORDS     (RSVD_WORDS),
        .KEY_WORD       (16'h08AA),
        .DEFAULT_TIMING (DEF_TIMING)
    ) u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_vld   (word_vld),
        .word       (word),
        .wr_req     (wr_req),
        .load       (load),
        .load_addr  (load_addr),
        .halted     (halted),
        .data_phase (data_phase),
        .timing_val (timing_val),
        .timing_vld (timing_vld),
        .entry_addr (entry_addr),
        .done       (done),
        .key_err    (key_err)
    );

    bl_write_port #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_wport (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (load_addr),
        .wr_req    (wr_req),
        .wr_in     (word),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/boot_stream_loader_chk.sv
module boot_stream_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        in_ready,
    input logic        wr_stb,
    input logic [15:0] timing_val,
    input logic        timing_vld,
    input logic [31:0] entry_addr,
    input logic        done,
    input logic        key_err
);
    logic err_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_seen_q <= 1'b0;
        else if (start)   err_seen_q <= 1'b0;
        else if (key_err) err_seen_q <= 1'b1;
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |=> !key_err);

    a_r2_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && key_err));

    a_r2_no_write_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_seen_q |-> !wr_stb);

    a_r8_halt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !in_ready);

    a_r8_halt_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        (key_err && !start) |=> !in_ready);

    a_r3_override_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_vld && !start) |=> timing_vld);

    a_r3_override_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        timing_vld |-> (timing_val != 16'h0000));

    a_r5_entry_steady: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $stable(entry_addr));
endmodule

bind boot_stream_loader boot_stream_loader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_ready   (in_ready),
    .wr_stb     (wr_stb),
    .timing_val (timing_val),
    .timing_vld (timing_vld),
    .entry_addr (entry_addr),
    .done       (done),
    .key_err    (key_err)
);

// File: tb/boot_stream_loader_tb.sv
`timescale 1ns/1ps
module boot_stream_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        wr_stb;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    logic [15:0] timing_val;
    logic        timing_vld;
    logic [31:0] entry_addr;
    logic        done;
    logic        key_err;

    always #4 clk = ~clk;

    boot_stream_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .timing_val(timing_val), .timing_vld(timing_vld),
        .entry_addr(entry_addr), .done(done), .key_err(key_err)
    );

    int tests = 0;
    int fails = 0;
    int writes = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int stalls = 0;
    logic [47:0] exp_q[$];

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [31:0] a, input logic [15:0] d);
        exp_q.push_back({a, d});
    endtask

    // monitor: scoreboard and pulse counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (key_err) err_cnt++;
            if (in_valid && !in_ready) stalls++;
            if (wr_stb) begin
                logic [47:0] e;
                writes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected write", wr_addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(wr_addr == e[47:16], "R6 write address", wr_addr, e[47:16]);
                    check(wr_data == e[15:0], "R1/R6 write data", {16'h0, wr_data}, {16'h0, e[15:0]});
                end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        send_byte(w[7:0]);
        send_byte(w[15:8]);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_header(input logic [15:0] rsvd0, input logic [31:0] ep);
        send_word(16'h08AA);
        send_word(rsvd0);
        for (int i = 1; i < 8; i++) send_word(16'h0000);
        send_word(ep[31:16]);
        send_word(ep[15:0]);
    endtask

    task automatic send_block(input logic [31:0] a, input logic [15:0] n,
                              input logic [15:0] base);
        send_word(n);
        send_word(a[31:16]);
        send_word(a[15:0]);
        for (int i = 0; i < int'(n); i++) begin
            expect_wr(a + 32'(i), base + 16'(i * 16'h1111));
            send_word(base + 16'(i * 16'h1111));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(in_ready == 1'b1, "R8 ready after reset", {31'h0, in_ready}, 32'h1);
        check(timing_val == 16'h1309, "R4 default timing", {16'h0, timing_val}, 32'h1309);
        check(timing_vld == 1'b0, "R4 no override at reset", {31'h0, timing_vld}, 32'h0);
        check(wr_stb == 1'b0 && done == 1'b0, "R7 idle outputs", {31'h0, done}, 32'h0);

        // image A: override, two blocks, second crosses 16-bit boundary
        send_header(16'h7AC0, 32'h0012_3456);
        send_block(32'h0000_8000, 16'd3, 16'h1111);
        send_block(32'h0000_FFFF, 16'd2, 16'hBEEF);
        send_word(16'h0000);
        idle(6);
        check(done_cnt == 1, "R7 one done pulse", done_cnt, 1);
        check(entry_addr == 32'h0012_3456, "R5 entry address", entry_addr, 32'h0012_3456);
        check(timing_vld == 1'b1, "R3 override flagged", {31'h0, timing_vld}, 32'h1);
        check(timing_val == 16'h7AC0, "R3 override value", {16'h0, timing_val}, 32'h7AC0);
        check(exp_q.size() == 0 && writes == 5, "R6 all writes seen", writes, 5);
        check(stalls > 0, "R9 stall during pending write", stalls, 1);
        check(in_ready == 1'b0, "R8 halted after done", {31'h0, in_ready}, 32'h0);

        // image B: zero first reserved word keeps default
        pulse_start();
        check(timing_val == 16'h1309 && timing_vld == 1'b0, "R8 start restores timing",
              {15'h0, timing_vld, timing_val}, 32'h1309);
        check(in_ready == 1'b1, "R8 ready after start", {31'h0, in_ready}, 32'h1);
        send_header(16'h0000, 32'h8000_0000);
        send_block(32'h0000_2000, 16'd1, 16'h5A5A);
        send_word(16'h0000);
        idle(6);
        check(done_cnt == 2, "R7 done for image B", done_cnt, 2);
        check(timing_vld == 1'b0 && timing_val == 16'h1309, "R4 zero keeps default",
              {15'h0, timing_vld, timing_val}, 32'h1309);
        check(entry_addr == 32'h8000_0000, "R5 entry address B", entry_addr, 32'h8000_0000);
        check(writes == 6, "R6 single-word block", writes, 6);

        // bad key
        pulse_start();
        send_word(16'h08AB);
        idle(6);
        check(err_cnt == 1, "R2 key error pulse", err_cnt, 1);
        check(done_cnt == 2, "R2 no done on bad key", done_cnt, 2);
        check(writes == 6, "R2 no writes on bad key", writes, 6);
        check(in_ready == 1'b0, "R2 halted on bad key", {31'h0, in_ready}, 32'h0);

        // partial stream then start: odd byte count must be discarded
        pulse_start();
        send_word(16'h08AA);
        send_word(16'h0055);
        send_byte(8'h33);
        pulse_start();
        send_header(16'h0001, 32'h0000_0100);
        send_block(32'h1234_0000, 16'd2, 16'h0A0B);
        send_word(16'h0000);
        idle(6);
        check(done_cnt == 3, "R8 restart mid-image", done_cnt, 3);
        check(timing_val == 16'h0001 && timing_vld, "R3 override after restart",
              {15'h0, timing_vld, timing_val}, 32'h10001);
        check(entry_addr == 32'h0000_0100, "R1 pairing after restart", entry_addr, 32'h100);
        check(exp_q.size() == 0 && writes == 8, "R9 no byte lost", writes, 8);
        check(err_cnt == 1, "R2 no spurious key error", err_cnt, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule